// File: doc/BRIEF.md
# Cartridge Bank-Switching Register Controller

This block sits on the CPU write path of a game cartridge and holds the bank registers that map a large program ROM and a large character ROM into small address windows. The CPU programs it through three decoded registers: two select registers and one shared data register. The select register written most recently decides what a data write means. The first select register aims data at one of four 8 KiB program windows. The second aims data at one shared outer character latch or at one of eight 1 KiB character windows.

Alongside the write side, two lookup paths run in parallel. A CPU address is turned into the 4-bit program bank of the window it falls in. A 13-bit pattern-table address is turned into the 12-bit character bank of its 1 KiB window. The lookups are purely combinational over the stored registers, so a bank written on one clock edge is visible from that edge onwards.

Top module: `bank_map_ctrl`

## Requirements
- R1: A write is decoded by ANDing its address with $E003. $8000 is select register A, $8002 is select register B and $8001 is the data register, so mirrors such as $9FFC and $9F01 behave the same. Writes to any other masked address, such as $8003, $A001, $C000, $E001 or anything below $8000, change nothing.
- R2: A data write is interpreted by the select register, A or B, that received the latest write. The other select register keeps its value but has no effect.
- R3: With select register A the latest and holding $26, $25, $24 or $23, a data write sets the program bank for the window at $8000, $A000, $C000 or $E000 respectively. No program window is fixed.
- R4: The 4-bit program bank is data bits 5..2 in reversed order: bank bit 3 is data bit 2 and bank bit 0 is data bit 5.
- R5: prg_bank_o shows the bank of the window selected by prg_addr_i bits 14..13 when bit 15 is 1, and is 0 for addresses below $8000.
- R6: With select register B the latest and holding any even value from $08 to $1E, a data write stores the full byte in the single outer character latch.
- R7: With select register B the latest and holding $09, $0B, $0D, $0F, $11, $15, $19 or $1D, a data write sets character window 0 to 7 ($0000, $0400, ... $1C00) to (latch << 4) OR (data >> 1), 12 bits.
- R8: For character windows 1 ($0400) and 3 ($0C00), bit 0 of the stored bank is forced to 1 on every write.
- R9: The outer latch is sampled when a window is written; later latch writes leave stored character banks unchanged.
- R10: A data write while the governing select register holds a value with no listed target changes no bank and not the latch.
- R11: After reset both select registers, all bank registers and the outer latch are 0, and select register A governs.
- R12: chr_bank_o shows the bank of the 1 KiB window selected by chr_addr_i bits 12..10; a bank write is seen on the lookup outputs from the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_wr_i | input | 1 | CPU write strobe, one write per cycle it is high |
| cpu_addr_i | input | 16 | CPU write address |
| cpu_data_i | input | 8 | CPU write data |
| prg_addr_i | input | 16 | CPU address to translate |
| prg_bank_o | output | 4 | Program bank for prg_addr_i |
| chr_addr_i | input | 13 | Pattern-table address to translate |
| chr_bank_o | output | 12 | Character bank for chr_addr_i |

## Verification
The write side and the lookup side can act on the same window in the same cycle: a data write updates a character window while chr_addr_i already points into that window. The bench parks the lookup address on the target window, raises the write, and samples chr_bank_o just before the edge, where it must still show the old bank, and again just after, where it must show the new one. The same overlap arises between a latch write and a previously written window, which is judged by the window keeping its bank.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  localparam int ADDR_W      = 16;
  localparam int DATA_W      = 8;
  localparam int PRG_WINDOWS = 4;
  localparam int PRG_BANK_W  = 4;
  localparam int PRG_LSB     = 2;
  localparam int CHR_WINDOWS = 8;
  localparam int CHR_BANK_W  = 12;
  localparam int CHR_ADDR_W  = 13;
  localparam int OUTER_W     = 8;
  localparam int INNER_W     = DATA_W - 1;

  localparam int PRG_IDX_W   = $clog2(PRG_WINDOWS);
  localparam int CHR_IDX_W   = $clog2(CHR_WINDOWS);
  localparam int OUTER_SHIFT = CHR_BANK_W - OUTER_W;

  typedef enum logic {
    SRC_SEL_A = 1'b0,
    SRC_SEL_B = 1'b1
  } sel_src_e;

  typedef struct packed {
    logic                  prg_we;
    logic [PRG_IDX_W-1:0]  prg_idx;
    logic [PRG_BANK_W-1:0] prg_val;
    logic                  outer_we;
    logic [OUTER_W-1:0]    outer_val;
    logic                  chr_we;
    logic [CHR_IDX_W-1:0]  chr_idx;
    logic [INNER_W-1:0]    inner_val;
  } bank_cmd_t;

endpackage

// File: rtl/bmc_rst_sync.sv
module bmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bmc_decode.sv
module bmc_decode
  import bmc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_MASK  = 16'hE003,
  parameter logic [ADDR_W-1:0] SEL_A_ADR = 16'h8000,
  parameter logic [ADDR_W-1:0] DATA_ADR  = 16'h8001,
  parameter logic [ADDR_W-1:0] SEL_B_ADR = 16'h8002,
  parameter logic [DATA_W-1:0] PRG_TOP   = 8'h26,
  parameter logic [DATA_W-1:0] PRG_BOT   = 8'h23,
  parameter logic [DATA_W-1:0] OUTER_LO  = 8'h08,
  parameter logic [DATA_W-1:0] OUTER_HI  = 8'h1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output bank_cmd_t         cmd_o
);

  logic [ADDR_W-1:0] masked;
  logic              hit_sel_a, hit_sel_b, hit_data;
  logic              sel_a_en, sel_b_en, src_en;
  logic [DATA_W-1:0] sel_a_q, sel_b_q;
  sel_src_e          src_q, src_d;
  logic              data_we;
  logic [DATA_W-1:0] prg_off;

  // address decode
  always_comb begin
    masked    = addr_i & REG_MASK;
    hit_sel_a = (masked == SEL_A_ADR);
    hit_sel_b = (masked == SEL_B_ADR);
    hit_data  = (masked == DATA_ADR);
    sel_a_en  = wr_i & hit_sel_a;
    sel_b_en  = wr_i & hit_sel_b;
    src_en    = sel_a_en | sel_b_en;
    src_d     = sel_a_en ? SRC_SEL_A : SRC_SEL_B;
    data_we   = wr_i & hit_data;
  end

  // select registers and latest-source flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_a_q <= '0;
      sel_b_q <= '0;
      src_q   <= SRC_SEL_A;
    end else begin
      if (sel_a_en) sel_a_q <= data_i;
      if (sel_b_en) sel_b_q <= data_i;
      if (src_en)   src_q   <= src_d;
    end
  end

  // data-write interpretation
  always_comb begin
    cmd_o          = '0;
    cmd_o.outer_val = data_i;
    cmd_o.inner_val = data_i[DATA_W-1:1];
    prg_off        = PRG_TOP - sel_a_q;
    cmd_o.prg_idx  = prg_off[PRG_IDX_W-1:0];
    for (int i = 0; i < PRG_BANK_W; i++) begin
      cmd_o.prg_val[i] = data_i[PRG_LSB + PRG_BANK_W - 1 - i];
    end
    if (data_we) begin
      if (src_q == SRC_SEL_A) begin
        cmd_o.prg_we = (sel_a_q >= PRG_BOT) && (sel_a_q <= PRG_TOP);
      end else if (!sel_b_q[0]) begin
        cmd_o.outer_we = (sel_b_q >= OUTER_LO) && (sel_b_q <= OUTER_HI);
      end else begin
        cmd_o.chr_we = 1'b1;
        case (sel_b_q)
          8'h09:   cmd_o.chr_idx = 3'd0;
          8'h0B:   cmd_o.chr_idx = 3'd1;
          8'h0D:   cmd_o.chr_idx = 3'd2;
          8'h0F:   cmd_o.chr_idx = 3'd3;
          8'h11:   cmd_o.chr_idx = 3'd4;
          8'h15:   cmd_o.chr_idx = 3'd5;
          8'h19:   cmd_o.chr_idx = 3'd6;
          8'h1D:   cmd_o.chr_idx = 3'd7;
          default: cmd_o.chr_we  = 1'b0;
        endcase
      end
    end
  end

  // a select write hands control to that register with the written value
  assert_sel_a_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && hit_sel_a) |=> (src_q == SRC_SEL_A) && (sel_a_q == $past(data_i)));
  assert_sel_b_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && hit_sel_b) |=> (src_q == SRC_SEL_B) && (sel_b_q == $past(data_i)));
  // R1: writes that miss the decoded registers leave select state alone
  assert_miss_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && (hit_sel_a || hit_sel_b)) |=> $stable(sel_a_q) && $stable(sel_b_q) && $stable(src_q));

endmodule

// File: rtl/bmc_prg_file.sv
module bmc_prg_file
  import bmc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [PRG_IDX_W-1:0]  idx_i,
  input  logic [PRG_BANK_W-1:0] val_i,
  input  logic                  in_rom_i,
  input  logic [PRG_IDX_W-1:0]  look_idx_i,
  output logic [PRG_BANK_W-1:0] bank_o
);

  logic [PRG_WINDOWS-1:0]                 win_en;
  logic [PRG_WINDOWS-1:0][PRG_BANK_W-1:0] bank_q;

  for (genvar w = 0; w < PRG_WINDOWS; w++) begin : g_en
    assign win_en[w] = we_i && (idx_i == PRG_IDX_W'(w));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else begin
      for (int w = 0; w < PRG_WINDOWS; w++) begin
        if (win_en[w]) bank_q[w] <= val_i;
      end
    end
  end

  always_comb bank_o = in_rom_i ? bank_q[look_idx_i] : '0;

  // R10: without a program write all program banks hold
  assert_prg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(bank_q));
  // R3: exactly one window may change per write
  assert_prg_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_en));

endmodule

// File: rtl/bmc_chr_file.sv
module bmc_chr_file
  import bmc_pkg::*;
#(
  parameter logic [CHR_WINDOWS-1:0] FORCE_LSB = 8'b0000_1010
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  outer_we_i,
  input  logic [OUTER_W-1:0]    outer_val_i,
  input  logic                  chr_we_i,
  input  logic [CHR_IDX_W-1:0]  chr_idx_i,
  input  logic [INNER_W-1:0]    inner_val_i,
  input  logic [CHR_IDX_W-1:0]  look_idx_i,
  output logic [CHR_BANK_W-1:0] bank_o
);

  logic [OUTER_W-1:0]                     outer_q;
  logic [CHR_BANK_W-1:0]                  merged;
  logic [CHR_WINDOWS-1:0]                 win_en;
  logic [CHR_WINDOWS-1:0][CHR_BANK_W-1:0] bank_d;
  logic [CHR_WINDOWS-1:0][CHR_BANK_W-1:0] bank_q;

  always_comb begin
    merged = (CHR_BANK_W'(outer_q) << OUTER_SHIFT) | CHR_BANK_W'(inner_val_i);
  end

  for (genvar w = 0; w < CHR_WINDOWS; w++) begin : g_win
    assign win_en[w] = chr_we_i && (chr_idx_i == CHR_IDX_W'(w));
    if (FORCE_LSB[w]) begin : g_force
      assign bank_d[w] = merged | CHR_BANK_W'(1);
    end else begin : g_plain
      assign bank_d[w] = merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outer_q <= '0;
      bank_q  <= '0;
    end else begin
      if (outer_we_i) outer_q <= outer_val_i;
      for (int w = 0; w < CHR_WINDOWS; w++) begin
        if (win_en[w]) bank_q[w] <= bank_d[w];
      end
    end
  end

  always_comb bank_o = bank_q[look_idx_i];

  // R8: windows 1 and 3 read back with bit 0 set after any write to them
  assert_force_w1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_we_i && chr_idx_i == CHR_IDX_W'(1)) |=> bank_q[1][0]);
  assert_force_w3_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_we_i && chr_idx_i == CHR_IDX_W'(3)) |=> bank_q[3][0]);
  // R9: a latch write never disturbs stored character banks
  assert_outer_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (outer_we_i && !chr_we_i) |=> $stable(bank_q));
  // R7: a window write takes the latch as it stood at that edge
  assert_outer_used_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_we_i && chr_idx_i == CHR_IDX_W'(0)) |=>
      bank_q[0][CHR_BANK_W-1:INNER_W] == $past(outer_q[OUTER_W-1:INNER_W-OUTER_SHIFT]));

endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
  import bmc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_wr_i,
  input  logic [ADDR_W-1:0]     cpu_addr_i,
  input  logic [DATA_W-1:0]     cpu_data_i,
  input  logic [ADDR_W-1:0]     prg_addr_i,
  output logic [PRG_BANK_W-1:0] prg_bank_o,
  input  logic [CHR_ADDR_W-1:0] chr_addr_i,
  output logic [CHR_BANK_W-1:0] chr_bank_o
);

  localparam int PRG_WIN_LSB = ADDR_W - 1 - PRG_IDX_W;
  localparam int CHR_WIN_LSB = CHR_ADDR_W - CHR_IDX_W;

  logic      rst_sync_n;
  bank_cmd_t cmd;
  logic      unused_addr_bits;

  assign unused_addr_bits = ^{prg_addr_i[PRG_WIN_LSB-1:0], chr_addr_i[CHR_WIN_LSB-1:0]};

  bmc_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bmc_decode dec_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_i   (cpu_wr_i),
    .addr_i (cpu_addr_i),
    .data_i (cpu_data_i),
    .cmd_o  (cmd)
  );

  bmc_prg_file prg_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .we_i       (cmd.prg_we),
    .idx_i      (cmd.prg_idx),
    .val_i      (cmd.prg_val),
    .in_rom_i   (prg_addr_i[ADDR_W-1]),
    .look_idx_i (prg_addr_i[ADDR_W-2 -: PRG_IDX_W]),
    .bank_o     (prg_bank_o)
  );

  bmc_chr_file chr_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .outer_we_i  (cmd.outer_we),
    .outer_val_i (cmd.outer_val),
    .chr_we_i    (cmd.chr_we),
    .chr_idx_i   (cmd.chr_idx),
    .inner_val_i (cmd.inner_val),
    .look_idx_i  (chr_addr_i[CHR_ADDR_W-1 -: CHR_IDX_W]),
    .bank_o      (chr_bank_o)
  );

  // R10/R1: only one kind of bank update per cycle
  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones({cmd.prg_we, cmd.outer_we, cmd.chr_we}) <= 1);

endmodule

// File: tb/bank_map_ctrl_tb_top.sv
`timescale 1ns/1ps
module bank_map_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr_i = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_data_i = '0;
  logic [15:0] prg_addr_i = '0;
  logic [3:0]  prg_bank_o;
  logic [12:0] chr_addr_i = '0;
  logic [11:0] chr_bank_o;

  int checks = 0;
  int errors = 0;

  // requirement-level model
  logic [7:0]  m_sel_a = '0, m_sel_b = '0, m_latch = '0;
  bit          m_src_b = 1'b0;
  logic [3:0]  m_prg [4];
  logic [11:0] m_chr [8];

  always #4 clk = ~clk;

  bank_map_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr_i(cpu_wr_i), .cpu_addr_i(cpu_addr_i),
    .cpu_data_i(cpu_data_i), .prg_addr_i(prg_addr_i), .prg_bank_o(prg_bank_o),
    .chr_addr_i(chr_addr_i), .chr_bank_o(chr_bank_o));

  task automatic chk(input string req, input string what, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: %s got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic int chr_target(input logic [7:0] s);
    int codes[8] = '{8'h09, 8'h0B, 8'h0D, 8'h0F, 8'h11, 8'h15, 8'h19, 8'h1D};
    for (int i = 0; i < 8; i++) if (s == codes[i]) return i;
    return -1;
  endfunction

  function automatic void model_wr(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] m;
    int t;
    m = a & 16'hE003;
    if (m == 16'h8000) begin m_sel_a = d; m_src_b = 1'b0; end
    else if (m == 16'h8002) begin m_sel_b = d; m_src_b = 1'b1; end
    else if (m == 16'h8001) begin
      if (!m_src_b) begin
        if (m_sel_a >= 8'h23 && m_sel_a <= 8'h26)
          m_prg[8'h26 - m_sel_a] = {d[2], d[3], d[4], d[5]};
      end else if (m_sel_b >= 8'h08 && m_sel_b <= 8'h1E && !m_sel_b[0]) begin
        m_latch = d;
      end else begin
        t = chr_target(m_sel_b);
        if (t >= 0)
          m_chr[t] = ({m_latch, 4'h0} | {5'h0, d[7:1]} | ((t == 1 || t == 3) ? 12'h1 : 12'h0));
      end
    end
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr_i = 1'b1; cpu_addr_i = a; cpu_data_i = d;
    @(negedge clk);
    cpu_wr_i = 1'b0;
    model_wr(a, d);
  endtask

  task automatic check_all(input string req);
    for (int w = 0; w < 4; w++) begin
      prg_addr_i = {1'b1, w[1:0], 13'h0ABC};
      #0.2;
      chk(req, $sformatf("prg window %0d", w), {8'h0, prg_bank_o}, {8'h0, m_prg[w]});
    end
    prg_addr_i = 16'h7FFF;  // R5: below program space
    #0.2;
    chk(req, "prg below $8000 (R5)", {8'h0, prg_bank_o}, 12'h0);
    for (int w = 0; w < 8; w++) begin
      chr_addr_i = {w[2:0], 10'h2A7};
      #0.2;
      chk(req, $sformatf("chr window %0d (R12)", w), chr_bank_o, m_chr[w]);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run not complete, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_prg[i] = '0;
    for (int i = 0; i < 8; i++) m_chr[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    check_all("R11");

    // R3 / R4: every program target with every data byte
    for (int s = 8'h23; s <= 8'h26; s++) begin
      for (int d = 0; d < 256; d++) begin
        wr(16'h8000, 8'(s));
        wr(16'h8001, 8'(d));
        prg_addr_i = {1'b1, 2'(8'h26 - s), 13'h0};
        #0.2;
        chk("R4", $sformatf("reversed bits sel %h data %h", s, d), {8'h0, prg_bank_o},
            {8'h0, d[2], d[3], d[4], d[5]});
      end
    end
    check_all("R3");

    // R2: latest select register wins
    wr(16'h8002, 8'h09);
    wr(16'h8000, 8'h25);
    wr(16'h8001, 8'h3C);
    check_all("R2");
    wr(16'h8002, 8'h0D);
    wr(16'h8001, 8'h55);
    check_all("R2");

    // R6 / R7: latch values against every window
    for (int l = 0; l < 256; l += 17) begin
      wr(16'h8002, 8'(8'h08 + 2 * (l % 12)));
      wr(16'h8001, 8'(l));
      for (int w = 0; w < 8; w++) begin
        int codes[8] = '{8'h09, 8'h0B, 8'h0D, 8'h0F, 8'h11, 8'h15, 8'h19, 8'h1D};
        wr(16'h8002, 8'(codes[w]));
        wr(16'h8001, 8'((l * 3 + w * 29) % 256));
      end
      check_all("R7");
    end
    check_all("R6");

    // R8: forced low bit with zero latch and zero data
    wr(16'h8002, 8'h08); wr(16'h8001, 8'h00);
    wr(16'h8002, 8'h0B); wr(16'h8001, 8'h00);
    wr(16'h8002, 8'h0F); wr(16'h8001, 8'h00);
    wr(16'h8002, 8'h09); wr(16'h8001, 8'h00);
    chr_addr_i = 13'h0400; #0.2; chk("R8", "window 1 forced", chr_bank_o, 12'h001);
    chr_addr_i = 13'h0C00; #0.2; chk("R8", "window 3 forced", chr_bank_o, 12'h001);
    chr_addr_i = 13'h0000; #0.2; chk("R8", "window 0 not forced", chr_bank_o, 12'h000);

    // R9: latch sampled at the window write
    wr(16'h8002, 8'h1E); wr(16'h8001, 8'hA5);
    wr(16'h8002, 8'h11); wr(16'h8001, 8'h10);
    wr(16'h8002, 8'h0A); wr(16'h8001, 8'h3C);
    chr_addr_i = 13'h1000; #0.2; chk("R9", "window 4 after latch rewrite", chr_bank_o, 12'hA58);
    wr(16'h8002, 8'h19); wr(16'h8001, 8'h02);
    chr_addr_i = 13'h1800; #0.2; chk("R9", "window 6 uses new latch", chr_bank_o, 12'h3C1);
    check_all("R9");

    // R10: unlisted select values do nothing
    for (int s = 0; s < 256; s++) begin
      if (s < 8'h23 || s > 8'h26) begin
        wr(16'h8000, 8'(s));
        wr(16'h8001, 8'(8'hFF - s));
      end
    end
    check_all("R10");
    for (int s = 0; s < 256; s++) begin
      if (chr_target(8'(s)) < 0 && !(s >= 8'h08 && s <= 8'h1E && s % 2 == 0)) begin
        wr(16'h8002, 8'(s));
        wr(16'h8001, 8'(s ^ 8'h5A));
      end
    end
    check_all("R10");
    wr(16'h8002, 8'h1D); wr(16'h8001, 8'h00);  // latch must still be $3C
    chr_addr_i = 13'h1C00; #0.2; chk("R10", "latch untouched", chr_bank_o, 12'h3C0);

    // R1: mirrors decode, other addresses ignored
    wr(16'h9FFC, 8'h24);
    wr(16'h9F01, 8'hFF);
    prg_addr_i = 16'hC000; #0.2; chk("R1", "mirrored write", {8'h0, prg_bank_o}, 12'h00F);
    wr(16'h8003, 8'h00); wr(16'hA001, 8'h00); wr(16'hC000, 8'h00);
    wr(16'hE001, 8'h00); wr(16'h0001, 8'h00); wr(16'h6002, 8'h25);
    wr(16'hA001, 8'h00);
    check_all("R1");

    // R12: write and lookup of the same window in one cycle
    wr(16'h8002, 8'h15);
    chr_addr_i = 13'h1555;
    @(negedge clk);
    cpu_wr_i = 1'b1; cpu_addr_i = 16'h8001; cpu_data_i = 8'hEE;
    #3.5;
    chk("R12", "before edge", chr_bank_o, m_chr[5]);
    @(negedge clk);
    cpu_wr_i = 1'b0;
    model_wr(16'h8001, 8'hEE);
    chk("R12", "after edge", chr_bank_o, 12'h3F7);
    check_all("R12");

    // R11: reset again clears everything
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) m_prg[i] = '0;
    for (int i = 0; i < 8; i++) m_chr[i] = '0;
    m_latch = '0; m_sel_a = '0; m_sel_b = '0; m_src_b = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R11");
    wr(16'h8001, 8'hFF);  // select A = 0 governs: no effect
    check_all("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule